// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Threshold Flags

This block is a single-clock FIFO with an 18-bit data path and a parameterized depth. It has two read timing modes, and the mode is chosen at master reset. In standard mode a word leaves storage only when a read is requested. In fall-through mode the oldest word moves to the output register without a read. In that mode the empty flag becomes an active-low output-ready, and the full flag becomes an active-low input-ready. Fall-through mode therefore holds one more word than the memory.

The block raises three threshold flags from the word count: almost-empty, almost-full and half-full. Two offset registers set the almost-empty and almost-full thresholds. At master reset these registers take a small or a large default, chosen by an input level, and a load strobe can write new values through the data input. A retransmit input rewinds the read side to the first stored location. A partial reset empties the FIFO and keeps the mode and the offsets.

Top module: `dual_mode_fifo`

## Requirements
- R1: On master reset (`mrst`=1) the mode is latched from `mode_in` (1 = fall-through) and the FIFO empties. After reset in standard mode `ef_or`=0 and `ff_ir`=1. After reset in fall-through mode `ef_or`=1 and `ff_ir`=0. Reset clears `dout` to 0.
- R2: In standard mode, a read with the FIFO not empty loads the oldest word into `dout` at that clock edge. Words leave in write order. A written word never reaches `dout` without a read. `ef_or`=1 exactly when the word count is non-zero. A read and a write in the same cycle leave the count unchanged.
- R3: In fall-through mode, the oldest stored word reaches `dout` with no read, and `ef_or` then goes to 0. A read while `ef_or`=0 consumes the shown word, and the next word (if any) appears at the same edge.
- R4: The memory accepts at most DEPTH words. The fall-through total is DEPTH+1 counting the output register. A write while the memory is full is ignored, and a cycle with `wr_en`=0 writes nothing. Full is shown as `ff_ir`=0 in standard mode and as `ff_ir`=1 in fall-through mode.
- R5: A read while no word is available is ignored, and `dout` keeps its previous value. A write in the same cycle is still accepted.
- R6: `pae`=1 exactly when the word count is less than or equal to the empty offset.
- R7: `paf`=1 exactly when the word count plus the full offset is at least DEPTH.
- R8: `hf`=1 exactly when the word count exceeds DEPTH/2.
- R9: Master reset loads both offsets with OFF_LO (default 2) when `big_off`=0, or with OFF_HI (default 4) when `big_off`=1.
- R10: A cycle with `load_off`=1 and `wr_en`=1 writes `din[AW:0]` into an offset register instead of the FIFO. The first such cycle after a reset writes the empty offset, the next writes the full offset, and the order then alternates.
- R11: `rexmit` moves the read position back to location 0. The readable count then becomes the number of words written since the last reset, capped at DEPTH. In fall-through mode `ef_or` reads 1 in the cycle after `rexmit`, and the first word is shown one cycle later.
- R12: Partial reset (`prst`=1) empties the FIFO. It keeps the mode and both offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| mode_in | input | 1 | Mode sampled at master reset: 1 = fall-through |
| big_off | input | 1 | Offset default select sampled at master reset |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| load_off | input | 1 | Redirects writes into the offset registers |
| rexmit | input | 1 | Retransmit: rewind the read side |
| din | input | W | Write data, or offset value when loading |
| dout | output | W | Output data register |
| ef_or | output | 1 | Empty flag (standard) / output-ready, active low (fall-through) |
| ff_ir | output | 1 | Full flag, active low (standard) / input-ready, active low (fall-through) |
| pae | output | 1 | Almost-empty flag |
| paf | output | 1 | Almost-full flag |
| hf | output | 1 | Half-full flag |

## Verification
A read and a write can occur in the same cycle. The bench drives both enables together when the FIFO is empty and again when it holds one word. When empty, the read must be ignored and `dout` must hold its previous value, while the write is still counted. When one word is held, the count must stay at one and `dout` must show the older word. A retransmit can also occur in the same cycle as a pending fall-through refill. For that case the bench checks that output-ready stays high for one cycle, and that the first word written is shown in the following cycle.

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int W      = 18,
  parameter int DEPTH  = 16,
  parameter int OFF_LO = 2,
  parameter int OFF_HI = 4
) (
  input  logic         clk,
  input  logic         mrst,
  input  logic         prst,
  input  logic         mode_in,
  input  logic         big_off,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic         load_off,
  input  logic         rexmit,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         ef_or,
  output logic         ff_ir,
  output logic         pae,
  output logic         paf,
  output logic         hf
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = AW + 1;
  localparam int CW = AW + 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] mcount, wr_total, cnt;
  logic [OW-1:0] e_off, f_off;
  logic          fwft, ov, ldsel;

  wire full  = mcount == CW'(DEPTH);
  wire empty = mcount == '0;
  wire do_wr = wr_en && !load_off && !full && !rexmit;
  wire pop   = fwft && rd_en && ov;
  wire do_rd = !rexmit && (fwft ? (!empty && (!ov || pop)) : (rd_en && !empty));

  assign cnt   = mcount + CW'(ov);
  assign ef_or = fwft ? !ov : !empty;
  assign ff_ir = fwft ? full : !full;
  assign pae   = cnt <= CW'(e_off);
  assign paf   = (cnt + CW'(f_off)) >= CW'(DEPTH);
  assign hf    = cnt > CW'(DEPTH / 2);

  always_ff @(posedge clk)
    if (!mrst && !prst && do_wr) mem[wptr] <= din;

  always_ff @(posedge clk) begin
    if (mrst || prst) begin
      wptr     <= '0;
      rptr     <= '0;
      mcount   <= '0;
      wr_total <= '0;
      ov       <= 1'b0;
      ldsel    <= 1'b0;
      if (mrst) begin
        dout  <= '0;
        fwft  <= mode_in;
        e_off <= big_off ? OW'(OFF_HI) : OW'(OFF_LO);
        f_off <= big_off ? OW'(OFF_HI) : OW'(OFF_LO);
      end
    end else if (rexmit) begin
      rptr   <= '0;
      mcount <= wr_total;
      ov     <= 1'b0;
    end else begin
      if (do_wr) begin
        wptr <= wptr + 1'b1;
        if (wr_total != CW'(DEPTH)) wr_total <= wr_total + 1'b1;
      end
      if (do_rd) begin
        dout <= mem[rptr];
        rptr <= rptr + 1'b1;
      end
      if (fwft) ov <= do_rd ? 1'b1 : (pop ? 1'b0 : ov);
      mcount <= mcount + CW'(do_wr) - CW'(do_rd);
      if (load_off && wr_en) begin
        if (ldsel) f_off <= din[OW-1:0];
        else       e_off <= din[OW-1:0];
        ldsel <= !ldsel;
      end
    end
  end

  p_full_block_r4: assert property (@(posedge clk) disable iff (mrst || prst)
    (full && wr_en && !rexmit) |=> $stable(wptr));
  p_mem_bound_r4: assert property (@(posedge clk) disable iff (mrst)
    mcount <= CW'(DEPTH));
  p_empty_hold_r5: assert property (@(posedge clk) disable iff (mrst || prst)
    (!fwft && empty && rd_en && !rexmit) |=> $stable(dout));
  p_fall_through_r3: assert property (@(posedge clk) disable iff (mrst || prst)
    (fwft && !ov && !empty && !rexmit) |=> !ef_or);
  p_load_no_write_r10: assert property (@(posedge clk) disable iff (mrst || prst)
    load_off |=> $stable(wptr));
  p_rexmit_setup_r11: assert property (@(posedge clk) disable iff (mrst || prst)
    (fwft && rexmit) |=> ef_or);
endmodule

// File: tb/test_dual_mode_fifo.sv
module test_dual_mode_fifo;
  localparam int P = 10;
  localparam int D = 16;

  logic clk = 0, mrst = 1, prst = 0, mode_in = 0, big_off = 0;
  logic wr_en = 0, rd_en = 0, load_off = 0, rexmit = 0;
  logic [17:0] din = 0, dout;
  logic ef_or, ff_ir, pae, paf, hf;
  int total = 0, bad = 0;
  bit done = 0;

  always #(P/2) clk = !clk;

  dual_mode_fifo i_dual_mode_fifo (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit wr, bit rd, bit ld, bit rx, int d);
    wr_en = wr; rd_en = rd; load_off = ld; rexmit = rx; din = 18'(d);
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; load_off = 0; rexmit = 0;
  endtask

  task automatic do_reset(bit master, bit md, bit big);
    mode_in = md; big_off = big;
    if (master) mrst = 1; else prst = 1;
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    mrst = 0; prst = 0;
  endtask

  task automatic flags(bit fw, int c, int eo, int fo, string tag);
    int mc = (fw && c > 0) ? c - 1 : c;
    chk({tag, " R2/R3 ef_or"}, ef_or, fw ? int'(c == 0) : int'(c != 0));
    chk({tag, " R4 ff_ir"}, ff_ir, fw ? int'(mc == D) : int'(mc != D));
    chk({tag, " R6 pae"}, pae, int'(c <= eo));
    chk({tag, " R7 paf"}, paf, int'(c + fo >= D));
    chk({tag, " R8 hf"}, hf, int'(c > D / 2));
  endtask

  initial begin
    #(P * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1, 0, 0);
    chk("R1 std ef_or", ef_or, 0);
    chk("R1 std ff_ir", ff_ir, 1);
    chk("R1 dout", dout, 0);
    flags(0, 0, 2, 2, "R9 low defaults");
    for (int i = 0; i < D + 2; i++) begin
      step(1, 0, 0, 0, 100 + i);
      if (i == 0) chk("R2 no read no output", dout, 0);
      flags(0, (i + 1 < D) ? i + 1 : D, 2, 2, "std fill");
    end
    for (int i = 0; i < D; i++) begin
      step(0, 1, 0, 0, 0);
      chk("R2 order", dout, 100 + i);
      flags(0, D - 1 - i, 2, 2, "std drain");
    end
    step(0, 1, 0, 0, 0);
    chk("R5 read empty holds", dout, 115);
    step(1, 1, 0, 0, 7);
    chk("R5 rd+wr at empty", dout, 115);
    flags(0, 1, 2, 2, "R5 rd+wr count");
    step(1, 1, 0, 0, 8);
    chk("R2 rd+wr oldest", dout, 7);
    flags(0, 1, 2, 2, "R2 rd+wr count");
    step(0, 1, 0, 0, 0);
    chk("R2 last", dout, 8);
    step(1, 0, 1, 0, 5);
    step(1, 0, 1, 0, 3);
    chk("R10 load no write", ef_or, 0);
    do_reset(0, 1, 1);
    chk("R12 mode kept", ef_or, 0);
    for (int i = 0; i < D; i++) begin
      step(1, 0, 0, 0, 150 + i);
      flags(0, i + 1, 5, 3, "R10 R12 loaded offsets");
    end
    for (int i = 0; i < D; i++) begin
      step(0, 1, 0, 0, 0);
      chk("R2 order2", dout, 150 + i);
    end
    do_reset(0, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 200 + i);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0);
    chk("R11 pre", dout, 202);
    step(0, 0, 0, 1, 0);
    flags(0, 6, 5, 3, "R11 std rewind");
    for (int i = 0; i < 6; i++) begin
      step(0, 1, 0, 0, 0);
      chk("R11 std replay", dout, 200 + i);
    end
    flags(0, 0, 5, 3, "R11 std end");

    do_reset(1, 1, 1);
    chk("R1 fw ef_or", ef_or, 1);
    chk("R1 fw ff_ir", ff_ir, 0);
    for (int i = 0; i < D + 2; i++) begin
      step(1, 0, 0, 0, 300 + i);
      step(0, 0, 0, 0, 0);
      if (i == 0) chk("R3 fall through", dout, 300);
      flags(1, (i + 1 < D + 1) ? i + 1 : D + 1, 4, 4, "R9 high fw fill");
    end
    for (int i = 0; i <= D; i++) begin
      step(0, 1, 0, 0, 0);
      chk("R3 fw order", dout, 300 + ((i + 1 < D) ? i + 1 : D));
      flags(1, D - i, 4, 4, "fw drain");
    end
    step(0, 1, 0, 0, 0);
    chk("R5 fw read empty", dout, 316);
    do_reset(0, 0, 0);
    chk("R12 fw kept", ef_or, 1);
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 0, 0, 400 + i);
      step(0, 0, 0, 0, 0);
    end
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R3 fw read", dout, 402);
    step(0, 0, 0, 1, 0);
    chk("R11 fw setup not ready", ef_or, 1);
    step(0, 0, 0, 0, 0);
    chk("R11 fw first word", dout, 400);
    flags(1, 5, 4, 4, "R11 R12 fw rewind");
    for (int i = 1; i < 5; i++) begin
      step(0, 1, 0, 0, 0);
      chk("R11 fw replay", dout, 400 + i);
    end
    step(0, 1, 0, 0, 0);
    flags(1, 0, 4, 4, "R11 fw end");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule